// File: doc/BRIEF.md
# Buffer Watermark Flag Generator

This block tracks the fill level of one packet buffer while an external master streams 32-bit words into it across a synchronous FIFO port, one word per clock. It drives a registered watermark flag. The writer uses this flag only to stop a burst. Once the flag changes, the writer may still send a fixed number of words. That number comes from the configured watermark value, reduced by a four-word latency allowance. The usable part of the buffer leaves out a reserved header region at the start and a footer region at the end.

The watermark value, the comparison direction and the pin polarity are sampled only on a commit pulse, which also releases the buffer and restarts the count. A buffer-full output blocks further counting. Writes that arrive while the buffer is full are dropped and raise a sticky overflow bit. The fill level, and the count captured at the last commit, are both available as outputs.

Top module: `wm_flag_gen`

## Requirements
- R1: The usable capacity is (BUF_BYTES - HDR_BYTES - FTR_BYTES) / (BUS_W/8) words, which is 4092 with defaults. Each clock with `wr_en` high, `full` low and `commit` low adds one to `fill_words`.
- R2: The remaining-space window is wm*(BUS_W/32) - 4 words, and the switch point is capacity minus window. A watermark of 253 on a 32-bit bus puts the switch after 3843 words (15372 bytes), leaving 249 words.
- R3: The flag is registered. It first shows the new state in the cycle after the strobe that carries the fill to the switch point, and it is unchanged during that strobe cycle.
- R4: With the direction select at 0, the flag is asserted while fill >= switch point. With the select at 1, it is asserted while fill < switch point.
- R5: With polarity select 1 (active low), the asserted level of the pin is 0 and the idle level is 1. With polarity select 0, the asserted level is 1.
- R6: `full` is 1 exactly when fill equals capacity. Writes in the window after the flag changes are accepted up to capacity. A write while full is dropped and sets `overflow`, which stays set until a commit.
- R7: On a commit, the next clock shows fill 0 and overflow 0. `commit_words` takes the fill held before the commit, and the flag level is that of fill 0 under the newly sampled settings. A write on the commit cycle is discarded.
- R8: The settings inputs have no effect except on a commit cycle. Out of reset, the active settings are watermark 253, direction 0 and polarity active low, so the pin reads 1.
- R9: A watermark of 4 or less gives a window of 0, so the switch point equals capacity. A window at or beyond capacity gives a switch point of 0, so the flag is asserted at fill 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per clock |
| commit | input | 1 | Releases the buffer and samples the settings |
| cfg_wm | input | WM_W (16) | Watermark value in bus words |
| cfg_on_data | input | 1 | Comparison direction select |
| cfg_active_low | input | 1 | Flag pin polarity |
| wm_flag | output | 1 | Registered watermark flag pin |
| full | output | 1 | Usable space exhausted |
| overflow | output | 1 | A write was dropped since the last commit |
| fill_words | output | CNT_W (12) | Words accepted into the current buffer |
| commit_words | output | CNT_W (12) | Fill level captured at the last commit |

## Verification
The bench builds the block with its default parameters: a 16384-byte buffer, 12 header bytes, 4 footer bytes and a 32-bit bus. With these values the 253-word case lands at exactly 15372 bytes, and the 4092-word capacity can be filled completely several times within the run. That makes full, the dropped writes, the clamped windows at both ends and the exact strobe on which the flag switches all reachable in every combination of direction and polarity.

// File: rtl/wm_flag_gen.sv
module wm_flag_gen #(
  parameter int unsigned BUF_BYTES = 16384,
  parameter int unsigned HDR_BYTES = 12,
  parameter int unsigned FTR_BYTES = 4,
  parameter int unsigned BUS_W = 32,
  parameter int unsigned WM_W = 16,
  parameter int unsigned LAT_WORDS = 4,
  parameter logic [WM_W-1:0] DEF_WM = 253,
  parameter bit DEF_ON_DATA = 1'b0,
  parameter bit DEF_ACT_LOW = 1'b1,
  localparam int unsigned WORD_BYTES = BUS_W / 8,
  localparam int unsigned USABLE = (BUF_BYTES - HDR_BYTES - FTR_BYTES) / WORD_BYTES,
  localparam int unsigned CNT_W = $clog2(USABLE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             commit,
  input  logic [WM_W-1:0]  cfg_wm,
  input  logic             cfg_on_data,
  input  logic             cfg_active_low,
  output logic             wm_flag,
  output logic             full,
  output logic             overflow,
  output logic [CNT_W-1:0] fill_words,
  output logic [CNT_W-1:0] commit_words
);

  localparam int unsigned SCALE = BUS_W / 32;

  function automatic logic [CNT_W-1:0] thr_of(input logic [WM_W-1:0] wm);
    int unsigned win;
    win = 32'(wm) * SCALE;
    if (win <= LAT_WORDS) win = 0;
    else win = win - LAT_WORDS;
    if (win >= USABLE) return '0;
    return CNT_W'(USABLE - win);
  endfunction

  function automatic logic pin_of(input logic [CNT_W-1:0] fill, input logic [CNT_W-1:0] thr,
                                  input logic on_data, input logic act_low);
    logic asserted;
    asserted = on_data ? (fill < thr) : (fill >= thr);
    return asserted ^ act_low;
  endfunction

  logic [CNT_W-1:0] fill_q, fill_d, thr_q, thr_d, cw_q;
  logic on_q, on_d, al_q, al_d, flag_q, ovf_q, accept;

  assign full         = (fill_q == CNT_W'(USABLE));
  assign accept       = wr_en && !full && !commit;
  assign wm_flag      = flag_q;
  assign overflow     = ovf_q;
  assign fill_words   = fill_q;
  assign commit_words = cw_q;

  always_comb begin
    fill_d = fill_q;
    thr_d  = thr_q;
    on_d   = on_q;
    al_d   = al_q;
    if (commit) begin
      fill_d = '0;
      thr_d  = thr_of(cfg_wm);
      on_d   = cfg_on_data;
      al_d   = cfg_active_low;
    end else if (accept) begin
      fill_d = fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      thr_q  <= thr_of(DEF_WM);
      on_q   <= DEF_ON_DATA;
      al_q   <= DEF_ACT_LOW;
      flag_q <= pin_of('0, thr_of(DEF_WM), DEF_ON_DATA, DEF_ACT_LOW);
      ovf_q  <= 1'b0;
      cw_q   <= '0;
    end else begin
      fill_q <= fill_d;
      thr_q  <= thr_d;
      on_q   <= on_d;
      al_q   <= al_d;
      flag_q <= pin_of(fill_d, thr_d, on_d, al_d);
      if (commit) begin
        ovf_q <= 1'b0;
        cw_q  <= fill_q;
      end else if (wr_en && full) begin
        ovf_q <= 1'b1;
      end
    end
  end

  p_fill_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_words <= CNT_W'(USABLE));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !commit) |=> fill_words == $past(fill_words) + CNT_W'(1));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !commit) |=> (full && overflow));

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !commit) |=> overflow);

  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (fill_words == '0 && !overflow && commit_words == $past(fill_words)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !wr_en) |=> $stable(wm_flag));

endmodule

// File: tb/sim_wm_flag_gen.sv
module sim_wm_flag_gen;
  localparam int CAP = 4092;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic commit = 1'b0;
  logic [15:0] cfg_wm = 16'd253;
  logic cfg_on_data = 1'b0;
  logic cfg_active_low = 1'b1;
  logic wm_flag, full, overflow;
  logic [11:0] fill_words, commit_words;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wm_flag_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .commit(commit),
    .cfg_wm(cfg_wm), .cfg_on_data(cfg_on_data), .cfg_active_low(cfg_active_low),
    .wm_flag(wm_flag), .full(full), .overflow(overflow),
    .fill_words(fill_words), .commit_words(commit_words)
  );

  function automatic int exp_thr(int wm);
    int win;
    win = (wm > 4) ? wm - 4 : 0;
    return (win >= CAP) ? 0 : CAP - win;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wr_en = 1'b1;
    end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic do_commit(int wm, bit od, bit al);
    @(negedge clk);
    cfg_wm = 16'(wm); cfg_on_data = od; cfg_active_low = al; commit = 1'b1;
    @(negedge clk) commit = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset flag", wm_flag, 1);
    chk("R6 reset full", full, 0);
    chk("R6 reset overflow", overflow, 0);
    chk("R1 reset fill", fill_words, 0);
    chk("R7 reset commit_words", commit_words, 0);
  endtask

  task automatic t_default_point;
    write_n(exp_thr(253) - 1);
    chk("R2 flag before switch", wm_flag, 1);
    @(negedge clk) wr_en = 1'b1;
    chk("R3 flag during strobe", wm_flag, 1);
    @(negedge clk) wr_en = 1'b0;
    chk("R3 flag after strobe", wm_flag, 0);
    chk("R2 fill at switch (15372 bytes)", fill_words * 4, 15372);
    write_n(CAP - 3843 - 1);
    chk("R6 not full one short", full, 0);
    write_n(1);
    chk("R6 window accepted to capacity", fill_words, CAP);
    chk("R6 full", full, 1);
    chk("R4 flag held low", wm_flag, 0);
    write_n(3);
    chk("R6 dropped write keeps fill", fill_words, CAP);
    chk("R6 overflow set", overflow, 1);
    write_n(0);
    chk("R6 overflow sticky", overflow, 1);
    do_commit(253, 0, 1);
    chk("R7 fill cleared", fill_words, 0);
    chk("R7 overflow cleared", overflow, 0);
    chk("R7 commit_words", commit_words, CAP);
    chk("R7 flag ready", wm_flag, 1);
  endtask

  task automatic t_cfg_ignored;
    @(negedge clk);
    cfg_wm = 16'd10; cfg_on_data = 1'b1; cfg_active_low = 1'b0;
    write_n(3900);
    chk("R8 settings ignored without commit", wm_flag, 0);
    do_commit(10, 1, 0);
    chk("R7 new settings at fill 0", wm_flag, 1);
    chk("R7 commit_words 3900", commit_words, 3900);
  endtask

  task automatic t_on_data_high;
    write_n(exp_thr(10) - 1);
    chk("R4 direction 1 asserted below point", wm_flag, 1);
    write_n(1);
    chk("R4 direction 1 released at point", wm_flag, 0);
    do_commit(253, 0, 0);
    chk("R5 active-high idle low", wm_flag, 0);
  endtask

  task automatic t_active_high;
    write_n(exp_thr(253) - 1);
    chk("R5 active-high before point", wm_flag, 0);
    write_n(1);
    chk("R5 active-high asserted", wm_flag, 1);
    do_commit(2, 0, 1);
  endtask

  task automatic t_clamp;
    write_n(CAP - 1);
    chk("R9 small wm: flag idle one short", wm_flag, 1);
    write_n(1);
    chk("R9 small wm: flag at capacity", wm_flag, 0);
    chk("R9 small wm: full", full, 1);
    do_commit(5000, 0, 1);
    chk("R9 huge window: asserted at fill 0", wm_flag, 0);
    do_commit(253, 0, 1);
    chk("R7 back to ready", wm_flag, 1);
  endtask

  task automatic t_commit_priority;
    write_n(5);
    @(negedge clk);
    wr_en = 1'b1; commit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; commit = 1'b0;
    chk("R7 write on commit discarded", fill_words, 0);
    chk("R7 commit_words 5", commit_words, 5);
    write_n(2);
    chk("R1 counting resumes", fill_words, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_point();
    t_cfg_ignored();
    t_on_data_high();
    t_active_high();
    t_clamp();
    t_commit_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule